// File: doc/BRIEF.md
# Thread Interrupt Priority Presenter

This block keeps the interrupt management context of one hardware thread. It has two independent rings, one for the operating system and one for the hypervisor. Each ring holds a pending-priority buffer with one bit per priority level, a derived pending-priority value, a current processor priority and a notification source byte. Pending-interrupt events arrive on a notify port. Each event carries a ring select and a priority from 0 to 7. When the most favored pending priority is numerically lower than the ring's current priority, the block raises that ring's interrupt line.

Software reaches the context through a register window made of four privilege pages. A two-bit page number picks the physical (0), hypervisor (1), OS (2) or user (3) view. Each access names a target ring and a command: read the status word, acknowledge, or set the current priority. Acknowledge is a load with side effects. It hands back the priority being taken, raises the current priority to it and retires that pending bit. All read data appears one cycle after the access.

Top module: `thread_irq_presenter`

## Requirements
- R1: After reset both rings have an empty pending buffer and a current priority of 0x00. Both interrupt lines are low, and a status read returns pending priority 0xFF.
- R2: A notify with ring r (0 = OS, 1 = hypervisor) and priority p sets bit p of ring r's pending buffer. Bits that are already set stay set.
- R3: The pending priority equals the index of the lowest-numbered set bit of the pending buffer, or 0xFF when the buffer is empty.
- R4: A ring's interrupt line is high exactly when its pending priority is numerically lower than its current priority. It follows any change of either value in the cycle after the change is registered. In the OS ring, bit 7 of the notification byte mirrors the line.
- R5: In the hypervisor ring, bits [7:6] of the notification byte read 2'b01 (physical exception) while its line is high and 2'b00 otherwise. No other code appears.
- R6: An acknowledge (command 1) on a ring whose line is high returns the pending priority in rd_data[7:0] with the upper bits zero. It copies that priority into the current priority and clears its pending bit. With the line low, it returns 0x000000FF and changes nothing.
- R7: A set-priority command (command 2) loads acc_wdata into the ring's current priority, and the interrupt line is re-evaluated against the new value.
- R8: Pages 0 and 1 give all commands on both rings. Page 2 gives all commands on the OS ring only. Page 3 allows only status reads of the OS ring. Any access outside these rights returns zero and changes no state. Command 3 always returns zero.
- R9: Activity on one ring never changes the other ring's state or line.
- R10: When a notify and an acknowledge hit the same pending bit in the same cycle, the bit stays set.
- R11: rd_valid is high in the cycle after each access. rd_data then holds the result. The status word is {notification byte, current priority, pending buffer, pending priority} from bit 31 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ntf_valid | input | 1 | Pending-interrupt event strobe |
| ntf_ring | input | 1 | Event target ring: 0 OS, 1 hypervisor |
| ntf_prio | input | 3 | Event priority |
| acc_valid | input | 1 | Register window access strobe |
| acc_page | input | 2 | Privilege page: 0 physical, 1 hypervisor, 2 OS, 3 user |
| acc_ring | input | 1 | Ring addressed by the access |
| acc_cmd | input | 2 | 0 status read, 1 acknowledge, 2 set priority, 3 reserved |
| acc_wdata | input | 8 | New current priority for command 2 |
| rd_valid | output | 1 | Read result valid, one cycle after an access |
| rd_data | output | 32 | Read result |
| irq_os | output | 1 | OS ring interrupt line |
| irq_hv | output | 1 | Hypervisor ring interrupt line |

## Verification
The bench drains every priority level in order through back-to-back acknowledges. A wrong priority encoder would hand back priorities out of order or leave the line stuck high. It acknowledges with nothing pending, where a design that skips the line check would corrupt the current priority instead of returning 0xFF. It probes every page and ring pair that lacks the right. A loose page decoder would leak status or let user code drop the hypervisor's priority. It also sets and retires the same bit in one cycle, where a clear-wins design would lose an interrupt.

// File: rtl/tip_pkg.sv
// Shared constants and encodings for the thread interrupt priority presenter.
// Assumes at most eight priority levels so every priority fits one byte.
package tip_pkg;
    localparam int          PRIO_LVLS = 8;
    localparam int          NUM_RINGS = 2;
    localparam logic [7:0]  PRIO_NONE = 8'hFF;

    typedef enum logic [1:0] {
        CMD_STATUS = 2'd0,
        CMD_ACK    = 2'd1,
        CMD_SETPRI = 2'd2,
        CMD_RSVD   = 2'd3
    } tip_cmd_e;

    typedef enum logic [1:0] {
        PG_PHYS = 2'd0,
        PG_HYP  = 2'd1,
        PG_OS   = 2'd2,
        PG_USER = 2'd3
    } tip_page_e;
endpackage

// File: rtl/tip_prio_pick.sv
// Finds the lowest-numbered set bit of a pending vector.
// Assumes nothing about the vector; found is low when it is empty.
module tip_prio_pick #(
    parameter int NUM_PRIO = 8,
    parameter int PRIO_W   = $clog2(NUM_PRIO)
) (
    input  logic [NUM_PRIO-1:0] vec,
    output logic                found,
    output logic [PRIO_W-1:0]   idx
);
    // Scan from the least favored down so the lowest set index wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_PRIO - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = PRIO_W'(i);
            end
        end
    end
endmodule

// File: rtl/tip_access_gate.sv
// Decodes page, ring and command into the operations the access may perform.
// Assumes ring 0 is the OS ring and ring 1 the hypervisor ring.
module tip_access_gate
    import tip_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_valid,
    input  logic [1:0] acc_page,
    input  logic       acc_ring,
    input  logic [1:0] acc_cmd,
    output logic       do_read,
    output logic       do_ack,
    output logic       do_setpri
);
    logic full_ok;
    logic read_ok;

    // Work out the rights that the page grants on the addressed ring.
    always_comb begin
        full_ok   = (acc_page == PG_PHYS) || (acc_page == PG_HYP) ||
                    (acc_page == PG_OS && !acc_ring);
        read_ok   = full_ok || (acc_page == PG_USER && !acc_ring);
        do_read   = acc_valid && read_ok && (acc_cmd == CMD_STATUS);
        do_ack    = acc_valid && full_ok && (acc_cmd == CMD_ACK);
        do_setpri = acc_valid && full_ok && (acc_cmd == CMD_SETPRI);
    end

    // R8
    user_no_modify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_page == PG_USER) |-> !(do_ack || do_setpri));
    // R8
    os_page_no_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_page == PG_OS && acc_ring) |-> !(do_read || do_ack || do_setpri));
endmodule

// File: rtl/tip_ring.sv
// One ring of the thread interrupt context: pending buffer, current priority,
// derived pending priority, notification byte and interrupt line.
// Assumes the caller never asserts ack_en and cppr_we in the same cycle.
module tip_ring
    import tip_pkg::*;
#(
    parameter int NUM_PRIO  = 8,
    parameter int PRIO_W    = $clog2(NUM_PRIO),
    parameter bit HV_LAYOUT = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [PRIO_W-1:0]   set_prio,
    input  logic                ack_en,
    input  logic                cppr_we,
    input  logic [7:0]          cppr_wdata,
    output logic [NUM_PRIO-1:0] ipb,
    output logic [7:0]          pipr,
    output logic [7:0]          cppr,
    output logic [7:0]          nsr,
    output logic                irq,
    output logic [7:0]          ack_prio
);
    logic                found;
    logic [PRIO_W-1:0]   best;
    logic                take;
    logic [NUM_PRIO-1:0] set_mask;
    logic [NUM_PRIO-1:0] clr_mask;

    tip_prio_pick #(.NUM_PRIO(NUM_PRIO), .PRIO_W(PRIO_W)) u_pick (
        .vec   (ipb),
        .found (found),
        .idx   (best)
    );

    // Derive the pending priority and compare it against the current one.
    always_comb begin
        pipr     = found ? 8'(best) : PRIO_NONE;
        irq      = pipr < cppr;
        take     = ack_en && irq;
        ack_prio = take ? pipr : PRIO_NONE;
    end

    // Build the pending-buffer set and clear masks for this cycle.
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (set_en) set_mask[set_prio] = 1'b1;
        if (take)   clr_mask[best]     = 1'b1;
    end

    // Update the pending buffer, where a new event beats a clear of the same bit.
    always_ff @(posedge clk) begin
        if (!rst_n) ipb <= '0;
        else        ipb <= (ipb & ~clr_mask) | set_mask;
    end

    // Update the current priority on acknowledge or an explicit write.
    always_ff @(posedge clk) begin
        if (!rst_n)       cppr <= 8'h00;
        else if (take)    cppr <= pipr;
        else if (cppr_we) cppr <= cppr_wdata;
    end

    // Pick the notification byte layout for this ring.
    generate
        if (HV_LAYOUT) begin : g_hv_nsr
            assign nsr = {(irq ? 2'b01 : 2'b00), 6'b0};
        end else begin : g_os_nsr
            assign nsr = {irq, 7'b0};
        end
    endgenerate

    // R2
    set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ipb[$past(set_prio)]);
    // R3
    empty_pipr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ipb == '0) |-> (pipr == PRIO_NONE));
    // R4
    irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ipb != '0));
    // R6
    ack_cppr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_en && irq) |=> (cppr == $past(pipr)));
    // R6
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_en && !irq && !set_en) |=> ($stable(cppr) && $stable(ipb)));
    // R7
    cppr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cppr_we && !ack_en) |=> (cppr == $past(cppr_wdata)));
endmodule

// File: rtl/thread_irq_presenter.sv
// Top of the thread interrupt priority presenter: two rings (OS, hypervisor),
// a page-based access gate and a registered read port.
// Assumes at most one access and one notify per cycle.
module thread_irq_presenter
    import tip_pkg::*;
#(
    parameter int NUM_PRIO = PRIO_LVLS,
    parameter int PRIO_W   = $clog2(NUM_PRIO),
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ntf_valid,
    input  logic              ntf_ring,
    input  logic [PRIO_W-1:0] ntf_prio,
    input  logic              acc_valid,
    input  logic [1:0]        acc_page,
    input  logic              acc_ring,
    input  logic [1:0]        acc_cmd,
    input  logic [7:0]        acc_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_os,
    output logic              irq_hv
);
    logic do_read;
    logic do_ack;
    logic do_setpri;

    logic [NUM_PRIO-1:0] r_ipb  [NUM_RINGS];
    logic [7:0]          r_pipr [NUM_RINGS];
    logic [7:0]          r_cppr [NUM_RINGS];
    logic [7:0]          r_nsr  [NUM_RINGS];
    logic [7:0]          r_ackp [NUM_RINGS];
    logic                r_irq  [NUM_RINGS];
    logic [31:0]         status [NUM_RINGS];

    tip_access_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_page  (acc_page),
        .acc_ring  (acc_ring),
        .acc_cmd   (acc_cmd),
        .do_read   (do_read),
        .do_ack    (do_ack),
        .do_setpri (do_setpri)
    );

    generate
        for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
            tip_ring #(
                .NUM_PRIO  (NUM_PRIO),
                .PRIO_W    (PRIO_W),
                .HV_LAYOUT (g == 1)
            ) u_ring (
                .clk        (clk),
                .rst_n      (rst_n),
                .set_en     (ntf_valid && (ntf_ring == 1'(g))),
                .set_prio   (ntf_prio),
                .ack_en     (do_ack && (acc_ring == 1'(g))),
                .cppr_we    (do_setpri && (acc_ring == 1'(g))),
                .cppr_wdata (acc_wdata),
                .ipb        (r_ipb[g]),
                .pipr       (r_pipr[g]),
                .cppr       (r_cppr[g]),
                .nsr        (r_nsr[g]),
                .irq        (r_irq[g]),
                .ack_prio   (r_ackp[g])
            );
            // Pack the status word for this ring.
            assign status[g] = {r_nsr[g], r_cppr[g], 8'(r_ipb[g]), r_pipr[g]};
        end
    endgenerate

    assign irq_os = r_irq[0];
    assign irq_hv = r_irq[1];

    // Register the read result one cycle after each access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc_valid;
            if (acc_valid) begin
                if (do_read)     rd_data <= DATA_W'(status[acc_ring]);
                else if (do_ack) rd_data <= DATA_W'(r_ackp[acc_ring]);
                else             rd_data <= '0;
            end
        end
    end

    // R11
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rd_valid);
    // R8
    user_hv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_page == PG_USER && acc_ring) |=> (rd_data == '0));
    // R9
    hv_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ntf_valid && ntf_ring) && !(acc_valid && acc_ring)) |=>
            ($stable(r_ipb[1]) && $stable(r_cppr[1])));
endmodule

// File: tb/thread_irq_presenter_tb.sv
`timescale 1ns/1ps
module thread_irq_presenter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ntf_valid = 1'b0;
    logic        ntf_ring = 1'b0;
    logic [2:0]  ntf_prio = '0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_page = '0;
    logic        acc_ring = 1'b0;
    logic [1:0]  acc_cmd = '0;
    logic [7:0]  acc_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        irq_os;
    logic        irq_hv;

    int total = 0;
    int bad = 0;
    int m_ipb [2];
    int m_cppr [2];

    thread_irq_presenter u_dut (
        .clk(clk), .rst_n(rst_n),
        .ntf_valid(ntf_valid), .ntf_ring(ntf_ring), .ntf_prio(ntf_prio),
        .acc_valid(acc_valid), .acc_page(acc_page), .acc_ring(acc_ring),
        .acc_cmd(acc_cmd), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .irq_os(irq_os), .irq_hv(irq_hv)
    );

    always #2 clk = ~clk;

    function automatic int m_pipr(input int r);
        for (int i = 0; i < 8; i++) if (m_ipb[r][i]) return i;
        return 255;
    endfunction

    function automatic bit m_irq(input int r);
        return m_pipr(r) < m_cppr[r];
    endfunction

    function automatic logic [31:0] m_status(input int r);
        int nsr;
        if (r == 0) nsr = m_irq(r) ? 8'h80 : 8'h00;
        else        nsr = m_irq(r) ? 8'h40 : 8'h00;
        return {8'(nsr), 8'(m_cppr[r]), 8'(m_ipb[r]), 8'(m_pipr(r))};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive inputs, advance the reference model, compare after the edge.
    task automatic step(input string tag, input bit nv, input int nr, input int np,
                        input bit av, input int pg, input int ar, input int cmd, input int wd);
        logic [31:0] exp_rd;
        bit full;
        bit rd_ok;
        int p;
        exp_rd = 32'h0;
        ntf_valid = nv; ntf_ring = 1'(nr); ntf_prio = 3'(np);
        acc_valid = av; acc_page = 2'(pg); acc_ring = 1'(ar);
        acc_cmd = 2'(cmd); acc_wdata = 8'(wd);
        if (av) begin
            full  = (pg < 2) || (pg == 2 && ar == 0);
            rd_ok = full || (pg == 3 && ar == 0);
            if (cmd == 0 && rd_ok) begin
                exp_rd = m_status(ar);
            end else if (cmd == 1 && full) begin
                p = m_pipr(ar);
                if (p < m_cppr[ar]) begin
                    exp_rd = 32'(p);
                    m_cppr[ar] = p;
                    m_ipb[ar] = m_ipb[ar] & ~(1 << p);
                end else begin
                    exp_rd = 32'hFF;
                end
            end else if (cmd == 2 && full) begin
                m_cppr[ar] = wd & 255;
            end
        end
        if (nv) m_ipb[nr] = m_ipb[nr] | (1 << np);
        @(posedge clk);
        @(negedge clk);
        ntf_valid = 1'b0;
        acc_valid = 1'b0;
        check({tag, " irq_os"}, 32'(irq_os), 32'(m_irq(0)));
        check({tag, " irq_hv"}, 32'(irq_hv), 32'(m_irq(1)));
        check({tag, " rd_valid"}, 32'(rd_valid), 32'(av));
        if (av) check({tag, " rd_data"}, rd_data, exp_rd);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic notify(input string tag, input int r, input int p);
        step(tag, 1, r, p, 0, 0, 0, 0, 0);
    endtask

    task automatic access(input string tag, input int pg, input int r, input int cmd, input int wd);
        step(tag, 0, 0, 0, 1, pg, r, cmd, wd);
    endtask

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_ipb[0] = 0; m_ipb[1] = 0; m_cppr[0] = 0; m_cppr[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        idle("R1 idle");
        access("R1 os status", 0, 0, 0, 0);
        access("R1 hv status", 0, 1, 0, 0);

        // R2 R3 set bits, pipr tracks the lowest; cppr 0 keeps the line low
        notify("R2 os p5", 0, 5);
        access("R3 os status", 2, 0, 0, 0);

        // R7 R4 open the OS priority, line rises, NSR bit 7
        access("R7 os cppr ff", 2, 0, 2, 8'hFF);
        access("R4 os status", 2, 0, 0, 0);
        notify("R3 os p2", 0, 2);
        access("R3 os status p2", 2, 0, 0, 0);

        // R6 acknowledge takes 2, then 5 is not below cppr 2
        access("R6 os ack", 2, 0, 1, 0);
        access("R6 os status after ack", 2, 0, 0, 0);
        access("R6 os ack empty-ish", 2, 0, 1, 0);
        access("R7 os cppr 6", 2, 0, 2, 6);

        // R5 hypervisor ring layout, R9 independence
        notify("R5 hv p3", 1, 3);
        access("R5 hv cppr ff", 1, 1, 2, 8'hFF);
        access("R5 hv status", 1, 1, 0, 0);
        access("R9 os status", 1, 0, 0, 0);

        // R8 privilege views
        access("R8 os page hv ack", 2, 1, 1, 0);
        access("R8 os page hv cppr", 2, 1, 2, 0);
        access("R8 os page hv status", 2, 1, 0, 0);
        access("R8 user os ack", 3, 0, 1, 0);
        access("R8 user os cppr", 3, 0, 2, 0);
        access("R8 user os status", 3, 0, 0, 0);
        access("R8 user hv status", 3, 1, 0, 0);
        access("R8 user hv cppr", 3, 1, 2, 0);
        access("R8 rsvd cmd", 0, 0, 3, 0);
        access("R8 phys hv status", 0, 1, 0, 0);

        // R10 notify and acknowledge of priority 5 in the same cycle
        step("R10 set+ack", 1, 0, 5, 1, 0, 0, 1, 0);
        access("R10 os status", 0, 0, 0, 0);

        // R6 R3 drain all priorities of the hypervisor ring in order
        access("R6 hv cppr ff", 0, 1, 2, 8'hFF);
        for (int p = 7; p >= 0; p--) notify("R2 hv fill", 1, p);
        for (int k = 0; k < 9; k++) begin
            access("R6 hv drain ack", 1, 1, 1, 0);
            access("R3 hv drain status", 1, 1, 0, 0);
            access("R7 hv reopen", 1, 1, 2, 8'hFF);
        end

        // R4 line re-evaluated on cppr drop below pending
        notify("R4 os p1", 0, 1);
        access("R4 os cppr 1", 0, 0, 2, 1);
        access("R4 os cppr 2", 0, 0, 2, 2);
        idle("R11 idle no valid");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule